// File: doc/BRIEF.md
# Qualified Latch-Off Overvoltage Detector

This block decides when a switching power controller must shut itself down for good because an overvoltage comparator on its protection pin keeps firing. It receives the comparator result as a single synchronous bit. It also receives the gate-drive signal, so it knows where each switching period starts and where the power switch turns off. Its single output is a flag that, once set, tells the rest of the controller to stop all driving pulses.

A comparator sample is trusted only after a blanking interval that starts at every gate turn-off edge. This hides the ringing caused by leakage inductance. A high level then counts as an event only if it lasts a minimum number of consecutive samples. A switching period holds at most one event. The flag sets when a run of consecutive switching periods have each held an event. A period without an event restarts the run. The flag then holds until the supply falls far enough to raise the power-on reset. All durations and the run length are parameters counted in system clock cycles.

Top module: `ovp_latch_qualifier`

## Requirements
- R1: While `por` is high, and on the first clock after it falls, `latched_off` is 0 and the run count and width filter are cleared.
- R2: The sample taken in the first clock where `gate_on` is low after being high is ignored, and so are the samples of the next BLANK_CYC-1 clocks. That makes BLANK_CYC ignored samples per turn-off.
- R3: A switching period holds an event only if `ovp_hi` is high for at least MIN_HI_CYC consecutive non-ignored samples. A shorter high level, or one cut short by blanking, is discarded.
- R4: A switching period is the interval between two rising edges of `gate_on`. Any number of events within one period count as a single event.
- R5: At a rising edge of `gate_on`, if the period just ended held an event, the run count grows by one. When the count reaches RUN_LEN, `latched_off` reads 1 from the next clock.
- R6: At a rising edge of `gate_on`, if the period just ended held no event, the run count returns to zero. A latch then needs RUN_LEN new consecutive event periods.
- R7: Once set, `latched_off` stays 1 whatever `gate_on` and `ovp_hi` do, until `por` is raised.
- R8: `latched_off` changes from 0 to 1 only in the clock that follows a rising edge of `gate_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| gate_on | input | 1 | Gate drive level; 1 = switch on |
| ovp_hi | input | 1 | Synchronous overvoltage comparator output |
| latched_off | output | 1 | Permanent shutdown flag |

## Verification
The bench sweeps the start offset and the length of a comparator pulse inside the off-time across the whole blanking edge and the minimum-width edge. A blanking window that is one sample off would turn a pulse that is one sample too short into an event, or lose a valid one. A width filter that is one off would do the same at the width edge. Two separate valid pulses in one off-time catch a design that counts events rather than periods, because it would latch after half the periods. A missing period in the middle of a run catches a count that is not cleared. Traffic after latching and a later power-on reset probe the hold and release of the flag.

// File: rtl/ovp_latch_qualifier.sv
module ovp_latch_qualifier #(
  parameter int BLANK_CYC  = 250,
  parameter int MIN_HI_CYC = 150,
  parameter int RUN_LEN    = 4
) (
  input  logic clk,
  input  logic por,
  input  logic gate_on,
  input  logic ovp_hi,
  output logic latched_off
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int HW = $clog2(MIN_HI_CYC + 1);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic          gate_q;
  logic [BW-1:0] blank_cnt;
  logic [HW-1:0] hi_cnt;
  logic [RW-1:0] run_cnt;
  logic          ev_seen;
  logic          lat_q;

  wire turn_off = gate_q & ~gate_on;
  wire period_start = ~gate_q & gate_on;
  wire blanked = turn_off | (blank_cnt != '0);
  wire sample = ovp_hi & ~blanked;
  wire qual = sample & (hi_cnt == HW'(MIN_HI_CYC - 1));

  assign latched_off = lat_q;

  always_ff @(posedge clk) begin
    if (por) begin
      gate_q    <= 1'b0;
      blank_cnt <= '0;
      hi_cnt    <= '0;
    end else begin
      gate_q <= gate_on;
      if (turn_off)
        blank_cnt <= BW'(BLANK_CYC - 1);
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
      if (!sample)
        hi_cnt <= '0;
      else if (hi_cnt != HW'(MIN_HI_CYC))
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      ev_seen <= 1'b0;
      run_cnt <= '0;
      lat_q   <= 1'b0;
    end else if (period_start) begin
      ev_seen <= qual;
      if (!lat_q) begin
        run_cnt <= ev_seen ? run_cnt + 1'b1 : '0;
        if (ev_seen && run_cnt == RW'(RUN_LEN - 1))
          lat_q <= 1'b1;
      end
    end else if (qual) begin
      ev_seen <= 1'b1;
    end
  end
endmodule

module ovp_latch_qualifier_chk #(
  parameter int BLANK_CYC = 250,
  parameter int HW = 8,
  parameter int RW = 3,
  parameter int RUN_LEN = 4
) (
  input logic clk,
  input logic por,
  input logic gate_on,
  input logic ovp_hi,
  input logic latched_off,
  input logic [HW-1:0] hi_cnt,
  input logic [RW-1:0] run_cnt
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  logic gq;
  logic [CW-1:0] left;
  wire fall_c = gq & ~gate_on;
  wire blank_c = fall_c | (left != '0);

  always_ff @(posedge clk) begin
    if (por) begin
      gq   <= 1'b0;
      left <= '0;
    end else begin
      gq <= gate_on;
      if (fall_c) left <= CW'(BLANK_CYC - 1);
      else if (left != '0) left <= left - 1'b1;
    end
  end

  assert_por_clears_R1: assert property (@(posedge clk) por |=> !latched_off);
  assert_blank_ignored_R2: assert property (@(posedge clk) disable iff (por)
    blank_c |=> hi_cnt == '0);
  assert_width_consecutive_R3: assert property (@(posedge clk) disable iff (por)
    hi_cnt != '0 |-> $past(ovp_hi));
  assert_run_bounded_R5: assert property (@(posedge clk) disable iff (por)
    run_cnt < RW'(RUN_LEN) || latched_off);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (por)
    latched_off |=> latched_off);
  assert_set_on_period_R8: assert property (@(posedge clk) disable iff (por)
    $rose(latched_off) |-> $past(gate_on) && !$past(gate_on, 2));
endmodule

bind ovp_latch_qualifier ovp_latch_qualifier_chk #(
  .BLANK_CYC(BLANK_CYC), .HW(HW), .RW(RW), .RUN_LEN(RUN_LEN)
) u_chk (
  .clk(clk), .por(por), .gate_on(gate_on), .ovp_hi(ovp_hi),
  .latched_off(latched_off), .hi_cnt(hi_cnt), .run_cnt(run_cnt)
);

// File: tb/ovp_latch_qualifier_bench.sv
module ovp_latch_qualifier_bench;
  localparam int BLANK = 4;
  localparam int MINHI = 3;
  localparam int RUN   = 4;
  localparam int ON    = 3;
  localparam int OFF   = 14;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic gate_on = 1'b0;
  logic ovp_hi = 1'b0;
  logic latched_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_run = 0;
  bit exp_lat = 1'b0;
  bit ev_pend = 1'b0;

  always #2 clk = ~clk;

  ovp_latch_qualifier #(.BLANK_CYC(BLANK), .MIN_HI_CYC(MINHI), .RUN_LEN(RUN)) u_ovp_latch_qualifier (
    .clk(clk), .por(por), .gate_on(gate_on), .ovp_hi(ovp_hi), .latched_off(latched_off)
  );

  function automatic bit is_event(int s, int l);
    int q;
    if (l <= 0) return 1'b0;
    q = s + l - ((s > BLANK) ? s : BLANK);
    return q >= MINHI;
  endfunction

  task automatic check(bit exp, string tag);
    checks++;
    if (latched_off !== exp) begin
      errors++;
      $display("FAIL %s latched_off actual %b expected %b", tag, latched_off, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    por = 1'b1; gate_on = 1'b0; ovp_hi = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 during por");
    por = 1'b0;
    exp_run = 0; exp_lat = 1'b0; ev_pend = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 after por");
  endtask

  task automatic sw_cycle(int s1, int l1, int s2, int l2, string tag);
    @(negedge clk);
    gate_on = 1'b1; ovp_hi = 1'b0;
    for (int i = 0; i < ON; i++) begin
      @(posedge clk);
      if (i == 0) begin
        if (!exp_lat) begin
          exp_run = ev_pend ? exp_run + 1 : 0;
          if (exp_run == RUN) exp_lat = 1'b1;
        end
        ev_pend = 1'b0;
      end
      @(negedge clk);
      check(exp_lat, tag);
    end
    for (int k = 0; k < OFF; k++) begin
      gate_on = 1'b0;
      ovp_hi = ((k >= s1) && (k < s1 + l1)) || ((k >= s2) && (k < s2 + l2));
      @(posedge clk);
      @(negedge clk);
      check(exp_lat, tag);
    end
    ovp_hi = 1'b0;
    ev_pend = is_event(s1, l1) | is_event(s2, l2);
  endtask

  initial begin
    do_reset();
    // R2 R3 R5 sweep of pulse offset and width against blanking and width edges
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 7; l++) begin
        do_reset();
        for (int c = 0; c < RUN; c++) sw_cycle(s, l, 0, 0, "R2 R3 R5 sweep");
        sw_cycle(0, 0, 0, 0, "R5 R8 sweep boundary");
        check(is_event(s, l), "R3 sweep final");
      end
    end
    // R6: a gap in the run restarts it
    do_reset();
    for (int c = 0; c < 3; c++) sw_cycle(5, 4, 0, 0, "R6 first run");
    sw_cycle(0, 0, 0, 0, "R6 gap");
    for (int c = 0; c < 3; c++) sw_cycle(5, 4, 0, 0, "R6 second run");
    sw_cycle(0, 0, 0, 0, "R6 after three");
    check(1'b0, "R6 not latched after broken run");
    do_reset();
    for (int c = 0; c < 3; c++) sw_cycle(5, 4, 0, 0, "R6 rerun");
    sw_cycle(6, 5, 0, 0, "R6 fourth");
    sw_cycle(0, 0, 0, 0, "R5 closing edge");
    check(1'b1, "R5 latched after full run");
    // R7: sticky under any traffic
    for (int c = 0; c < 3; c++) sw_cycle(0, 0, 0, 0, "R7 idle after latch");
    sw_cycle(1, 12, 0, 0, "R7 traffic after latch");
    check(1'b1, "R7 still latched");
    do_reset();
    check(1'b0, "R1 release by por");
    // R4: two valid pulses in one period count once
    for (int c = 0; c < 2; c++) sw_cycle(4, 3, 9, 4, "R4 double pulse");
    sw_cycle(0, 0, 0, 0, "R4 boundary");
    check(1'b0, "R4 two periods of double pulses do not latch");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule